// File: doc/BRIEF.md
# Single-Line Programmable Interrupt Controller

This block turns one external interrupt pin into a single interrupt request for a processor. Software picks how the pin is interpreted: active-low level, falling edge, active-high level or rising edge. A detected event is held in a pending flag. Writing a one to the flag clears it. An enable bit decides whether the flag reaches the interrupt output.

The pin goes through a two-flop synchroniser before any detection. Edges are found by comparing the synchronised value with its value one cycle earlier. Access is through a flat 32-bit register port. Writes happen on the clock edge and reads are combinational from the address. A parameter picks one of two address layouts for the three registers.

The usual bring-up order is: clear the enable, acknowledge any stale pending event, program the trigger mode, then set the enable. Masking and unmasking the source only flip the enable bit.

Top module: `line_irq_ctl`

## Requirements
- R1: During and right after reset, the control, pending and enable registers read as zero and `irq_out` is low.
- R2: The control register bits [1:0] hold the trigger mode: 0 = active-low level, 1 = falling edge, 2 = active-high level, 3 = rising edge. In an edge mode, only the selected edge sets the pending flag; the opposite edge leaves it unchanged.
- R3: In a level mode, the pending flag is set again on every cycle the synchronised input is at its active level. An acknowledge therefore clears the flag only once the input has gone inactive.
- R4: Pending status is bit 0 of the pending register. Once set, it stays set until a write with bit 0 = 1 reaches that register. A write with bit 0 = 0 leaves the status unchanged.
- R5: If an acknowledge and a new trigger event fall in the same cycle, the event wins and the pending flag stays set.
- R6: `irq_out` is high exactly when the pending flag is set and bit 0 of the enable register is 1. Clearing the enable masks the output without losing the pending flag.
- R7: Every bit of the control and enable registers, and bits [31:1] of the pending register, read back the last value written.
- R8: With `MAP_SEL` = 0 the control, pending and enable registers sit at byte offsets 0x00, 0x04 and 0x08. With `MAP_SEL` = 1 they sit at 0x0C, 0x10 and 0x40.
- R9: Reads of any other offset return zero, and writes to any other offset change no register.
- R10: A change on `irq_pin` that forms an event reaches `irq_out` on the third rising clock edge after it: two synchroniser stages, then the pending register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, taken on the rising clock edge |
| bus_addr | input | ADDR_W | Byte offset for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_pin | input | 1 | Raw external interrupt line, asynchronous |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
A wrong trigger-mode decode or a stuck synchroniser shows within three clock edges of a pin change, because `irq_out` and the pending bit either fail to rise or rise on the wrong edge. A pending flag that loses its hold, or ignores an acknowledge, shows on the next read of the pending register and on `irq_out` one cycle after the write. Address-decode errors show right away as non-zero reads from unmapped offsets, or as register contents changed by a stray write. The bench drives the same-cycle acknowledge/edge collision on an exact cycle, so that a priority inversion shows as a cleared flag.

// File: rtl/line_irq_ctl.sv
module line_irq_ctl #(
  parameter int ADDR_W  = 8,
  parameter bit MAP_SEL = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              irq_pin,
  output logic              irq_out
);

  localparam logic [ADDR_W-1:0] OFF_CTRL = MAP_SEL ? ADDR_W'(8'h0C) : ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] OFF_PEND = MAP_SEL ? ADDR_W'(8'h10) : ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] OFF_EN   = MAP_SEL ? ADDR_W'(8'h40) : ADDR_W'(8'h08);

  localparam logic [1:0] TRIG_LOW  = 2'd0;
  localparam logic [1:0] TRIG_FALL = 2'd1;
  localparam logic [1:0] TRIG_HIGH = 2'd2;
  localparam logic [1:0] TRIG_RISE = 2'd3;

  logic [31:0] ctrl_q, en_q;
  logic [31:1] pend_hi_q;
  logic        pend_q;
  logic        sync1_q, sync2_q, prev_q;
  logic        event_hit;

  wire hit_ctrl = bus_wr && (bus_addr == OFF_CTRL);
  wire hit_pend = bus_wr && (bus_addr == OFF_PEND);
  wire hit_en   = bus_wr && (bus_addr == OFF_EN);
  wire ack_hit  = hit_pend && bus_wdata[0];
  wire [1:0] trig = ctrl_q[1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      prev_q  <= 1'b0;
    end else begin
      sync1_q <= irq_pin;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
    end
  end

  always_comb begin
    unique case (trig)
      TRIG_LOW:  event_hit = !sync2_q;
      TRIG_FALL: event_hit = !sync2_q && prev_q;
      TRIG_HIGH: event_hit = sync2_q;
      TRIG_RISE: event_hit = sync2_q && !prev_q;
      default:   event_hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      en_q      <= '0;
      pend_hi_q <= '0;
      pend_q    <= 1'b0;
    end else begin
      if (hit_ctrl) ctrl_q <= bus_wdata;
      if (hit_en)   en_q   <= bus_wdata;
      if (hit_pend) pend_hi_q <= bus_wdata[31:1];
      if (event_hit)    pend_q <= 1'b1;
      else if (ack_hit) pend_q <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == OFF_CTRL)      bus_rdata = ctrl_q;
    else if (bus_addr == OFF_PEND) bus_rdata = {pend_hi_q, pend_q};
    else if (bus_addr == OFF_EN)   bus_rdata = en_q;
  end

  assign irq_out = pend_q && en_q[0];

  a_r5_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    event_hit |=> pend_q);

  a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !ack_hit) |=> pend_q);

  a_r4_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_hit && !event_hit) |=> !pend_q);

  a_r10_rise_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> $past(event_hit));

  a_r9_ctrl_guarded: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_ctrl |=> $stable(ctrl_q));

  a_r9_en_guarded: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_en |=> $stable(en_q));

endmodule

// File: tb/tb_line_irq_ctl.sv
`timescale 1ns/100ps
module tb_line_irq_ctl;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic          irq_pin = 1'b1;
  logic [31:0]   rdata_a, rdata_b;
  logic          irq_a, irq_b;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  line_irq_ctl #(.ADDR_W(AW), .MAP_SEL(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata_a), .irq_pin(irq_pin), .irq_out(irq_a));

  line_irq_ctl #(.ADDR_W(AW), .MAP_SEL(1'b1)) dut_b (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata_b), .irq_pin(irq_pin), .irq_out(irq_b));

  typedef struct {
    bit          sel_b;
    logic [31:0] exp_rd;
    bit          chk_irq;
    logic        exp_irq;
    string       tag;
  } item_t;

  item_t sb_q[$];
  event  smp;

  localparam logic [AW-1:0] A_CTRL = 8'h00, A_PEND = 8'h04, A_EN = 8'h08;
  localparam logic [AW-1:0] B_CTRL = 8'h0C, B_PEND = 8'h10, B_EN = 8'h40;

  initial begin
    forever begin
      @(smp);
      while (sb_q.size() > 0) begin
        item_t it;
        logic [31:0] got_rd;
        logic        got_irq;
        it = sb_q.pop_front();
        got_rd  = it.sel_b ? rdata_b : rdata_a;
        got_irq = it.sel_b ? irq_b : irq_a;
        checks++;
        if (got_rd !== it.exp_rd || (it.chk_irq && got_irq !== it.exp_irq)) begin
          errors++;
          $display("FAIL %s: rdata=%h exp=%h irq=%b exp=%b",
                   it.tag, got_rd, it.exp_rd, got_irq, it.exp_irq);
        end
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic chk(input bit sel_b, input logic [AW-1:0] a, input logic [31:0] e,
                     input bit ci, input logic ei, input string tag);
    item_t it;
    bus_addr = a;
    #1;
    it.sel_b = sel_b; it.exp_rd = e; it.chk_irq = ci; it.exp_irq = ei; it.tag = tag;
    sb_q.push_back(it);
    -> smp;
    wait (sb_q.size() == 0);
    @(negedge clk);
  endtask

  initial begin
    tick(3);
    chk(0, A_CTRL, 32'h0, 1, 1'b0, "R1 ctrl reset");
    chk(0, A_PEND, 32'h0, 1, 1'b0, "R1 pend reset");
    chk(0, A_EN,   32'h0, 1, 1'b0, "R1 en reset");
    rst_n = 1'b1;
    tick(3);
    chk(0, A_PEND, 32'h1, 1, 1'b0, "R6 stale level-low event masked");
    wr(A_EN, 32'h0);
    wr(A_PEND, 32'h1);
    chk(0, A_PEND, 32'h0, 1, 1'b0, "R4 bring-up ack");
    wr(A_CTRL, 32'hA5A5_0003);
    chk(0, A_CTRL, 32'hA5A5_0003, 1, 1'b0, "R7 ctrl readback");
    wr(A_EN, 32'h8000_0001);
    chk(0, A_EN, 32'h8000_0001, 1, 1'b0, "R7 en readback");

    irq_pin = 1'b0; tick(4);
    chk(0, A_PEND, 32'h0, 1, 1'b0, "R2 falling edge ignored in rising mode");
    irq_pin = 1'b1; tick(2);
    chk(0, A_PEND, 32'h0, 1, 1'b0, "R10 not before third edge");
    chk(0, A_PEND, 32'h1, 1, 1'b1, "R10 R2 rising edge latched");
    tick(3);
    chk(0, A_PEND, 32'h1, 1, 1'b1, "R4 sticky while unacked");
    wr(A_PEND, 32'h0000_00F0);
    chk(0, A_PEND, 32'h0000_00F1, 1, 1'b1, "R4 R7 write without bit0");
    wr(A_PEND, 32'h1);
    chk(0, A_PEND, 32'h0, 1, 1'b0, "R4 ack clears");

    irq_pin = 1'b0; tick(4);
    irq_pin = 1'b1; tick(2);
    wr(A_PEND, 32'h1);
    chk(0, A_PEND, 32'h1, 1, 1'b1, "R5 edge wins over ack");
    wr(A_PEND, 32'h1);
    chk(0, A_PEND, 32'h0, 1, 1'b0, "R4 ack after collision");

    wr(A_CTRL, 32'h1);
    irq_pin = 1'b0; tick(4);
    chk(0, A_PEND, 32'h1, 1, 1'b1, "R2 falling edge latched");
    wr(A_EN, 32'h0);
    chk(0, A_PEND, 32'h1, 1, 1'b0, "R6 masked keeps pending");
    wr(A_EN, 32'h1);
    chk(0, A_EN, 32'h1, 1, 1'b1, "R6 unmask");
    wr(A_PEND, 32'h1);
    irq_pin = 1'b1; tick(4);
    chk(0, A_PEND, 32'h0, 1, 1'b0, "R2 rising edge ignored in falling mode");

    wr(A_CTRL, 32'h2);
    tick(1);
    chk(0, A_PEND, 32'h1, 1, 1'b1, "R3 high level sets");
    wr(A_PEND, 32'h1);
    chk(0, A_PEND, 32'h1, 1, 1'b1, "R3 ack ignored while active");
    irq_pin = 1'b0; tick(4);
    chk(0, A_PEND, 32'h1, 1, 1'b1, "R3 held after inactive");
    wr(A_PEND, 32'h1);
    chk(0, A_PEND, 32'h0, 1, 1'b0, "R3 ack after inactive");

    wr(A_CTRL, 32'h0);
    tick(1);
    chk(0, A_PEND, 32'h1, 1, 1'b1, "R3 low level sets");
    irq_pin = 1'b1; tick(4);
    wr(A_PEND, 32'h1);
    chk(0, A_PEND, 32'h0, 1, 1'b0, "R3 low level ack");

    wr(8'h20, 32'hFFFF_FFFF);
    chk(0, 8'h20, 32'h0, 1, 1'b0, "R9 unmapped read");
    chk(0, A_CTRL, 32'h0, 1, 1'b0, "R9 unmapped write ignored ctrl");
    chk(0, A_EN, 32'h1, 1, 1'b0, "R9 unmapped write ignored en");

    wr(B_CTRL, 32'h1234_5672);
    chk(1, B_CTRL, 32'h1234_5672, 0, 1'b0, "R8 map B ctrl");
    chk(0, B_CTRL, 32'h0, 0, 1'b0, "R9 map A ignores 0x0C");
    chk(1, A_CTRL, 32'h0, 0, 1'b0, "R8 map B 0x00 unmapped");
    wr(B_EN, 32'h1);
    chk(1, B_EN, 32'h1, 0, 1'b0, "R8 map B en");
    chk(1, B_PEND, 32'h1, 1, 1'b1, "R8 map B pend and irq");
    irq_pin = 1'b0; tick(4);
    wr(B_PEND, 32'h1);
    chk(1, B_PEND, 32'h0, 1, 1'b0, "R8 map B ack");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: rdata=%h exp=%h", rdata_a, 32'h0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule